// File: doc/BRIEF.md
# Bidirectional Strobed Port Handshake Controller

This block runs the handshake for one 8-bit peripheral port that carries traffic both ways over a single shared set of pins. A host write fills an output holding register. That register is driven onto the shared port only while the peripheral holds its acknowledge line low. At all other times the port driver is released. A low peripheral strobe copies the port pins into a separate input holding register. Each direction keeps its own buffer-full flag and its own interrupt-enable flag. The two directions are merged into one interrupt request line.

Back-pressure runs through the two buffer-full flags rather than through a ready signal. While the output-full pin is low, the peripheral has not yet taken the last host write, so the host should not write again. While the input-full flag is high, the host has not yet read the last captured byte, so the peripheral should not strobe again. The block does not refuse transfers that break these rules: a new write or strobe replaces the held byte. The interrupt enables are changed by a single-bit set/reset command. A mode write clears every flag and enable. A status byte packs the flags for the host to poll.

All inputs are synchronous to `clk`. Host read and write are level signals, and the end of each, its falling level, is what completes the transfer.

Top module: `sbp_port`

## Requirements
- R1: A cycle with `host_wr` high loads `host_wdata` into the output register, which appears on `pa_out` after the next clock edge. A mode write does not clear this register.
- R2: `pa_oe` is high in exactly those cycles in which `ack_n` is low.
- R3: A cycle with `stb_n` low loads `pa_in` into the input register, shown on `host_rdata` after the next edge, and sets `ibf` at that edge.
- R4: The end of a host write (`host_wr` high in one cycle, low in the next) drives `obf_n` low at the following edge. This takes priority over a simultaneous low `ack_n`.
- R5: An edge that samples `ack_n` low, in a cycle that is not the end of a write, returns `obf_n` high.
- R6: The end of a host read (`host_rd` falling) clears `ibf` at the following edge, unless `stb_n` is low in that cycle.
- R7: `intr` = (`ibf` AND input enable AND `stb_n` high AND `host_rd` low) OR (output-full AND output enable AND `ack_n` high AND `host_wr` low). It responds to the live inputs in the same cycle.
- R8: A `bsr_wr` cycle with `bsr_sel`=6 writes `bsr_val` into the output enable. With `bsr_sel`=4 it writes the input enable. Any other `bsr_sel` value changes nothing visible.
- R9: `host_status` bit 7 = `obf_n` pin level, bit 6 = output enable, bit 5 = `ibf`, bit 4 = input enable, bit 3 = `intr`, and bits 2..0 = 0.
- R10: A `mode_wr` cycle clears both flags and both enables at the next edge, ahead of any set in the same cycle. Reset leaves the same cleared state, with both holding registers at zero.
- R11: The two directions run at the same time without affecting each other. A write and a strobe in the same cycle both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write pulse; clears flags and enables |
| bsr_wr | input | 1 | Single-bit set/reset command strobe |
| bsr_sel | input | 3 | Bit position addressed by the set/reset command |
| bsr_val | input | 1 | Value written by the set/reset command |
| host_wr | input | 1 | Host write level for the port |
| host_wdata | input | DW | Host write data |
| host_rd | input | 1 | Host read level for the port |
| host_rdata | output | DW | Input holding register |
| host_status | output | 8 | Packed status byte |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| pa_in | input | DW | Shared port pins, input side |
| pa_out | output | DW | Shared port pins, output side |
| pa_oe | output | 1 | Shared port driver enable |
| obf_n | output | 1 | Output-full pin, active low |
| ibf | output | 1 | Input-full flag |
| intr | output | 1 | Merged interrupt request |

## Verification
The assertions assume every input is a clean synchronous level that is sampled once per clock. They also assume that a write or read "ends" exactly when its level is seen to drop between two samples. Beyond that they assume nothing about ordering, so they hold for any mix of writes, acknowledges, strobes and reads.

The stimulus first runs the legal order, write before acknowledge and strobe before read, in directed sequences. This includes one cycle in which both directions start together. It then applies a long random stretch with sticky read and write levels and rare mode writes. That stretch reaches orderings outside the legal one as well, and the cycle model follows them.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int ST_W   = 8;
  localparam int ST_OBF = 7;
  localparam int ST_IEO = 6;
  localparam int ST_IBF = 5;
  localparam int ST_IEI = 4;
  localparam int ST_IRQ = 3;
  localparam logic [2:0] BSR_IEO = 3'd6;
  localparam logic [2:0] BSR_IEI = 3'd4;
endpackage

// File: rtl/sbp_outbuf.sv
module sbp_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_n,
  output logic [DW-1:0] q,
  output logic          full
);
  logic wr_q;
  logic wr_end;

  assign wr_end = wr_q & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      wr_q <= wr;
      if (wr) q <= wdata;
      if (clr)         full <= 1'b0;
      else if (wr_end) full <= 1'b1;
      else if (!ack_n) full <= 1'b0;
    end
  end
endmodule

// File: rtl/sbp_inbuf.sv
module sbp_inbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb_n,
  input  logic          rd,
  input  logic [DW-1:0] pin,
  output logic [DW-1:0] q,
  output logic          full
);
  logic rd_q;
  logic rd_end;

  assign rd_end = rd_q & ~rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd;
      if (!stb_n) q <= pin;
      if (clr)         full <= 1'b0;
      else if (!stb_n) full <= 1'b1;
      else if (rd_end) full <= 1'b0;
    end
  end
endmodule

// File: rtl/sbp_irq.sv
module sbp_irq
  import sbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bsr_wr,
  input  logic [2:0] bsr_sel,
  input  logic       bsr_val,
  input  logic       out_full,
  input  logic       in_full,
  input  logic       stb_n,
  input  logic       ack_n,
  input  logic       rd,
  input  logic       wr,
  output logic       ie_out,
  output logic       ie_in,
  output logic       intr
);
  logic req_in;
  logic req_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_out <= 1'b0;
      ie_in  <= 1'b0;
    end else if (clr) begin
      ie_out <= 1'b0;
      ie_in  <= 1'b0;
    end else if (bsr_wr) begin
      if (bsr_sel == BSR_IEO) ie_out <= bsr_val;
      if (bsr_sel == BSR_IEI) ie_in  <= bsr_val;
    end
  end

  assign req_in  = in_full  & ie_in  & stb_n & ~rd;
  assign req_out = out_full & ie_out & ack_n & ~wr;
  assign intr    = req_in | req_out;
endmodule

// File: rtl/sbp_port.sv
module sbp_port
  import sbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic          bsr_wr,
  input  logic [2:0]    bsr_sel,
  input  logic          bsr_val,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  output logic [7:0]    host_status,
  input  logic          ack_n,
  input  logic          stb_n,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  output logic          obf_n,
  output logic          ibf,
  output logic          intr
);
  logic out_full;
  logic ie_out;
  logic ie_in;

  sbp_outbuf #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .wr(host_wr),
    .wdata(host_wdata), .ack_n(ack_n), .q(pa_out), .full(out_full)
  );

  sbp_inbuf #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .stb_n(stb_n),
    .rd(host_rd), .pin(pa_in), .q(host_rdata), .full(ibf)
  );

  sbp_irq u_irq (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .bsr_wr(bsr_wr),
    .bsr_sel(bsr_sel), .bsr_val(bsr_val), .out_full(out_full),
    .in_full(ibf), .stb_n(stb_n), .ack_n(ack_n), .rd(host_rd),
    .wr(host_wr), .ie_out(ie_out), .ie_in(ie_in), .intr(intr)
  );

  assign pa_oe = ~ack_n;
  assign obf_n = ~out_full;

  always_comb begin
    host_status         = '0;
    host_status[ST_OBF] = obf_n;
    host_status[ST_IEO] = ie_out;
    host_status[ST_IBF] = ibf;
    host_status[ST_IEI] = ie_in;
    host_status[ST_IRQ] = intr;
  end
endmodule

// File: rtl/sbp_chk.sv
module sbp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic          bsr_wr,
  input logic [2:0]    bsr_sel,
  input logic          bsr_val,
  input logic          host_wr,
  input logic [DW-1:0] host_wdata,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic [7:0]    host_status,
  input logic          ack_n,
  input logic          stb_n,
  input logic [DW-1:0] pa_in,
  input logic [DW-1:0] pa_out,
  input logic          pa_oe,
  input logic          obf_n,
  input logic          ibf,
  input logic          intr
);
  p_out_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> pa_out == $past(host_wdata));

  p_drive_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pa_oe |-> !ack_n);

  p_in_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_n && !mode_wr) |=> ibf);

  p_in_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |=> host_rdata == $past(pa_in));

  p_obf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_wr) && !mode_wr) |=> !obf_n);

  p_obf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !$fell(host_wr)) |=> obf_n);

  p_ibf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_rd) && stb_n) |=> !ibf);

  p_intr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ((ibf && stb_n && !host_rd) || (!obf_n && ack_n && !host_wr)));

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (obf_n && !ibf && !intr && !host_status[6] && !host_status[4]));
endmodule

bind sbp_port sbp_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_sbp_port.sv
module tb_sbp_port;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic          bsr_wr = 1'b0;
  logic [2:0]    bsr_sel = '0;
  logic          bsr_val = 1'b0;
  logic          host_wr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_rd = 1'b0;
  logic          ack_n = 1'b1;
  logic          stb_n = 1'b1;
  logic [DW-1:0] pa_in = '0;
  logic [DW-1:0] host_rdata;
  logic [7:0]    host_status;
  logic [DW-1:0] pa_out;
  logic          pa_oe;
  logic          obf_n;
  logic          ibf;
  logic          intr;

  sbp_port #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
    .bsr_sel(bsr_sel), .bsr_val(bsr_val), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_status(host_status), .ack_n(ack_n), .stb_n(stb_n), .pa_in(pa_in),
    .pa_out(pa_out), .pa_oe(pa_oe), .obf_n(obf_n), .ibf(ibf), .intr(intr)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference state
  bit m_obf, m_ibf, m_ieo, m_iei, m_wrq, m_rdq;
  logic [7:0] m_out = '0;
  logic [7:0] m_in = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_obf = 0; m_ibf = 0; m_ieo = 0; m_iei = 0; m_wrq = 0; m_rdq = 0;
      m_out = '0; m_in = '0;
    end else begin
      if (mode_wr) begin
        m_obf = 0; m_ibf = 0; m_ieo = 0; m_iei = 0;
      end else begin
        if (m_wrq && !host_wr) m_obf = 1;
        else if (!ack_n)       m_obf = 0;
        if (!stb_n)                 m_ibf = 1;
        else if (m_rdq && !host_rd) m_ibf = 0;
        if (bsr_wr && bsr_sel == 3'd6) m_ieo = bsr_val;
        if (bsr_wr && bsr_sel == 3'd4) m_iei = bsr_val;
      end
      if (host_wr) m_out = host_wdata;
      if (!stb_n)  m_in = pa_in;
      m_wrq = host_wr;
      m_rdq = host_rd;
    end
  end

  function automatic logic m_intr();
    return (m_ibf && m_iei && stb_n && !host_rd) ||
           (m_obf && m_ieo && ack_n && !host_wr);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] st;
    st = {~m_obf, m_ieo, m_ibf, m_iei, m_intr(), 3'b000};
    chk("R1", "pa_out", pa_out, m_out);
    chk("R2", "pa_oe", {7'd0, pa_oe}, {7'd0, ~ack_n});
    chk("R3", "host_rdata", host_rdata, m_in);
    chk("R4", "obf_n", {7'd0, obf_n}, {7'd0, ~m_obf});
    chk("R6", "ibf", {7'd0, ibf}, {7'd0, m_ibf});
    chk("R7", "intr", {7'd0, intr}, {7'd0, m_intr()});
    chk("R9", "status", host_status, st);
  endtask

  task automatic cyc(input logic mw, input logic bw, input logic [2:0] bs,
                     input logic bv, input logic w, input logic [7:0] wd,
                     input logic r, input logic a, input logic s,
                     input logic [7:0] pi);
    @(negedge clk);
    mode_wr = mw; bsr_wr = bw; bsr_sel = bs; bsr_val = bv;
    host_wr = w; host_wdata = wd; host_rd = r; ack_n = a; stb_n = s; pa_in = pi;
    #1;
    compare_all();
  endtask

  task automatic idle();
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 1, 1, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // reset state, R10
    chk("R10", "reset status", host_status, 8'h80);
    chk("R10", "reset pa_out", pa_out, 8'h00);

    // enables, R8
    cyc(0, 1, 3'd6, 1, 0, 8'h00, 0, 1, 1, 8'h00);
    cyc(0, 1, 3'd4, 1, 0, 8'h00, 0, 1, 1, 8'h00);
    idle();
    chk("R8", "enables set", host_status, 8'hD0);
    cyc(0, 1, 3'd7, 0, 0, 8'h00, 0, 1, 1, 8'h00);
    cyc(0, 1, 3'd3, 1, 0, 8'h00, 0, 1, 1, 8'h00);
    idle();
    chk("R8", "other positions ignored", host_status, 8'hD0);

    // output handshake, R4 R5 R1 R2 R7
    cyc(0, 0, 3'd0, 0, 1, 8'hA5, 0, 1, 1, 8'h00);
    idle();
    idle();
    chk("R4", "obf_n after write", {7'd0, obf_n}, 8'h00);
    chk("R7", "intr output side", {7'd0, intr}, 8'h01);
    chk("R2", "released before ack", {7'd0, pa_oe}, 8'h00);
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 0, 1, 8'h00);
    chk("R2", "driven during ack", {7'd0, pa_oe}, 8'h01);
    chk("R1", "held data", pa_out, 8'hA5);
    chk("R7", "intr masked by ack low", {7'd0, intr}, 8'h00);
    idle();
    chk("R5", "obf_n after ack", {7'd0, obf_n}, 8'h01);

    // input handshake, R3 R6 R7
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 1, 0, 8'h3C);
    idle();
    chk("R3", "ibf after strobe", {7'd0, ibf}, 8'h01);
    chk("R3", "captured data", host_rdata, 8'h3C);
    chk("R7", "intr input side", {7'd0, intr}, 8'h01);
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 1, 1, 1, 8'h00);
    chk("R7", "intr drops during read", {7'd0, intr}, 8'h00);
    idle();
    chk("R6", "ibf held until read ends", {7'd0, ibf}, 8'h01);
    idle();
    chk("R6", "ibf after read", {7'd0, ibf}, 8'h00);

    // both directions together, R11
    cyc(0, 0, 3'd0, 0, 1, 8'h5A, 0, 1, 0, 8'h11);
    idle();
    idle();
    chk("R11", "concurrent status", host_status, 8'h78);
    chk("R11", "concurrent data in", host_rdata, 8'h11);

    // mode write, R10
    cyc(1, 0, 3'd0, 0, 0, 8'h00, 0, 1, 1, 8'h00);
    idle();
    chk("R10", "cleared status", host_status, 8'h80);
    chk("R10", "latch kept", pa_out, 8'h5A);

    // write end wins over ack low, R4 R5
    cyc(0, 1, 3'd6, 1, 1, 8'h77, 0, 0, 1, 8'h00);
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 0, 1, 8'h00);
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 0, 1, 8'h00);
    chk("R4", "set beats ack", {7'd0, obf_n}, 8'h00);
    cyc(0, 0, 3'd0, 0, 0, 8'h00, 0, 1, 1, 8'h00);
    chk("R5", "ack clears next", {7'd0, obf_n}, 8'h01);

    // random stretch against the model, all requirements
    for (int i = 0; i < 4000; i++) begin
      logic w, r, a, s, mw, bw;
      w  = ($urandom_range(0, 3) == 0) ? ~host_wr : host_wr;
      r  = ($urandom_range(0, 3) == 0) ? ~host_rd : host_rd;
      a  = ($urandom_range(0, 2) == 0) ? ~ack_n : ack_n;
      s  = ($urandom_range(0, 2) == 0) ? ~stb_n : stb_n;
      mw = ($urandom_range(0, 99) == 0);
      bw = ($urandom_range(0, 7) == 0);
      cyc(mw, bw, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          w, 8'($urandom), r, a, s, 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule